// File: doc/BRIEF.md
# Microprogrammed Multicycle Control Sequencer

This block steers a multicycle datapath from a small internal microprogram instead of a hand-built state machine. A 4-bit micro-address register selects one encoded microinstruction from a fixed store. Each microinstruction carries seven symbolic fields:

- the ALU operation
- the first ALU operand
- the second ALU operand
- the register-file action
- the memory action
- the program-counter update
- the sequencing choice

A field decoder turns these fields into the individual datapath strobes and select lines. The result is the same control word that a hardwired multicycle controller would give.

The next micro-address comes from a four-way selector. Its inputs are constant zero, the incremented address, and two lookup tables indexed by the 6-bit instruction opcode. The first lookup table branches out of the decode step by instruction class. The second separates loads from stores after the address step. The sequencing field of the current microinstruction picks one of these four sources on every clock.

The opcode input is only consulted in the two dispatch steps. The current micro-address is brought out so that the surrounding datapath and the bench can see which step is active.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it is released, the micro-address is 0 until the next rising clock edge. The outputs show the fetch control word of R6 to R9.
- R2: The sequencing field is encoded as follows: 00 returns to address 0, 01 uses lookup table 1, 10 uses lookup table 2, and 11 takes the current address plus one. Addresses 0, 3 and 6 advance by one. Address 1 uses table 1 and address 2 uses table 2. Addresses 4, 5, 7, 8 and 9 return to 0.
- R3: Lookup table 1 gives these targets: opcode 000000 (register-register) goes to 6, 000010 (jump) to 9, 000100 (branch-if-equal) to 8, and both 100011 (load) and 101011 (store) to 2.
- R4: Lookup table 2 sends opcode 100011 (load) to 3 and 101011 (store) to 5.
- R5: An opcode that is missing from the table in use sends the next micro-address to 0.
- R6: The ALU outputs `{alu_op, alu_a_sel, alu_b_sel}` per address are:
  - address 0: {00,0,01}
  - address 1: {00,0,11}
  - address 2: {00,1,10}
  - address 6: {10,1,00}
  - address 8: {01,1,00}
  - all other addresses: zero.

  Here alu_op 00 means add, 01 subtract and 10 function-field. alu_b_sel 00 means register B, 01 the constant 4, 10 the sign-extended offset and 11 the shifted offset.
- R7: The register outputs `{reg_wr, reg_dst, wb_from_mem}` are 101 at address 4 (write the memory data into the rt register), 110 at address 7 (write the ALU result into the rd register), and 000 elsewhere.
- R8: The memory outputs `{mem_rd, mem_wr, ir_wr, mem_addr_alu}` are 1010 at address 0 (fetch from the PC address), 1001 at address 3, 0101 at address 5, and 0000 elsewhere.
- R9: The PC outputs `{pc_wr, pc_wr_cond, pc_src}` are 1000 at address 0, 0101 at address 8 (conditional write from the ALU result register), 1010 at address 9 (jump target), and 0000 elsewhere.
- R10: A change of opcode has no effect on the next micro-address except at addresses 1 and 2.
- R11: Store entries 10 to 15 hold an all-zero word with sequencing 00, and the micro-address never goes above 9 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the held instruction |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the ALU zero flag |
| mem_addr_alu | output | 1 | Memory address from the ALU result register (0: from PC) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data from the memory data register |
| pc_src | output | 2 | PC source select |
| alu_op | output | 2 | ALU operation class |
| alu_a_sel | output | 1 | First ALU operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | Second ALU operand select |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination register: 0 rt, 1 rd |
| upc | output | 4 | Current micro-address |

## Verification
Each of the 64 opcodes is held steady from reset through a full instruction. This shows whether the decode branch picks the right class path and whether unknown opcodes fall back to fetch. It also compares every step's control groups against the expected field meanings. A second run changes the opcode on every clock, drawing from a mix of valid and invalid codes with no reset in between. This tells apart a sequencer that samples the opcode only in its two dispatch steps from one that lets the opcode leak into incremented or return steps. Because load and store share the first table entry, the second table is the only place where their paths split, and both paths are checked to their last step.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  localparam int UPC_W = 4;
  localparam int OP_W  = 6;
  localparam int DEPTH = 1 << UPC_W;
  localparam int USED  = 10;

  localparam logic [OP_W-1:0] OPC_RR    = 6'b000000;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'b000010;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_FUNC = 2'd2} alu_fld_e;
  typedef enum logic       {S1_PC = 1'b0, S1_A = 1'b1} src1_fld_e;
  typedef enum logic [1:0] {S2_B = 2'd0, S2_FOUR = 2'd1, S2_EXT = 2'd2, S2_EXTSH = 2'd3} src2_fld_e;
  typedef enum logic [1:0] {RG_NONE = 2'd0, RG_WR_ALU = 2'd1, RG_WR_MDR = 2'd2} reg_fld_e;
  typedef enum logic [1:0] {MM_NONE = 2'd0, MM_RD_PC = 2'd1, MM_RD_ALU = 2'd2, MM_WR_ALU = 2'd3} mem_fld_e;
  typedef enum logic [1:0] {PW_NONE = 2'd0, PW_ALU = 2'd1, PW_COND = 2'd2, PW_JUMP = 2'd3} pcw_fld_e;
  typedef enum logic [1:0] {SQ_FETCH = 2'b00, SQ_DISP1 = 2'b01, SQ_DISP2 = 2'b10, SQ_NEXT = 2'b11} seq_fld_e;

  typedef struct packed {
    alu_fld_e  alu;
    src1_fld_e src1;
    src2_fld_e src2;
    reg_fld_e  rg;
    mem_fld_e  mem;
    pcw_fld_e  pcw;
    seq_fld_e  seq;
  } uinstr_t;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       mem_addr_alu;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_from_mem;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic [1:0] alu_b_sel;
    logic       alu_a_sel;
    logic       reg_wr;
    logic       reg_dst;
  } ctrl_t;

  typedef struct packed {
    logic             hit;
    logic [UPC_W-1:0] tgt;
  } disp_t;

  // Class branch taken out of the decode step.
  function automatic disp_t lookup_class(input logic [OP_W-1:0] op);
    disp_t d;
    d = '0;
    case (op)
      OPC_RR:              d = '{hit: 1'b1, tgt: 4'd6};
      OPC_JMP:             d = '{hit: 1'b1, tgt: 4'd9};
      OPC_BEQ:             d = '{hit: 1'b1, tgt: 4'd8};
      OPC_LOAD, OPC_STORE: d = '{hit: 1'b1, tgt: 4'd2};
      default:             d = '0;
    endcase
    return d;
  endfunction

  // Split between load and store after the address step.
  function automatic disp_t lookup_mem(input logic [OP_W-1:0] op);
    disp_t d;
    d = '0;
    case (op)
      OPC_LOAD:  d = '{hit: 1'b1, tgt: 4'd3};
      OPC_STORE: d = '{hit: 1'b1, tgt: 4'd5};
      default:   d = '0;
    endcase
    return d;
  endfunction

  // Symbolic microprogram; unlisted addresses hold the zero word.
  function automatic uinstr_t rom_word(input logic [UPC_W-1:0] a);
    uinstr_t w;
    w = '0;
    case (a)
      4'd0: begin w.src2 = S2_FOUR; w.mem = MM_RD_PC; w.pcw = PW_ALU; w.seq = SQ_NEXT; end
      4'd1: begin w.src2 = S2_EXTSH; w.seq = SQ_DISP1; end
      4'd2: begin w.src1 = S1_A; w.src2 = S2_EXT; w.seq = SQ_DISP2; end
      4'd3: begin w.mem = MM_RD_ALU; w.seq = SQ_NEXT; end
      4'd4: begin w.rg = RG_WR_MDR; w.seq = SQ_FETCH; end
      4'd5: begin w.mem = MM_WR_ALU; w.seq = SQ_FETCH; end
      4'd6: begin w.alu = ALU_FUNC; w.src1 = S1_A; w.src2 = S2_B; w.seq = SQ_NEXT; end
      4'd7: begin w.rg = RG_WR_ALU; w.seq = SQ_FETCH; end
      4'd8: begin w.alu = ALU_SUB; w.src1 = S1_A; w.pcw = PW_COND; w.seq = SQ_FETCH; end
      4'd9: begin w.pcw = PW_JUMP; w.seq = SQ_FETCH; end
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/ucs_store.sv
module ucs_store #(
  parameter int UPC_W = ucs_pkg::UPC_W,
  parameter int USED  = ucs_pkg::USED
) (
  input  logic [UPC_W-1:0] addr,
  output ucs_pkg::uinstr_t uinst
);
  localparam int DEPTH = 1 << UPC_W;

  ucs_pkg::uinstr_t tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i < USED) begin : g_prog
      assign tbl[i] = ucs_pkg::rom_word(UPC_W'(i));
    end else begin : g_blank
      assign tbl[i] = '0;
    end
  end

  assign uinst = tbl[addr];
endmodule

// File: rtl/ucs_next_addr.sv
module ucs_next_addr #(
  parameter int UPC_W = ucs_pkg::UPC_W,
  parameter int OP_W  = ucs_pkg::OP_W
) (
  input  logic [UPC_W-1:0]  cur,
  input  ucs_pkg::seq_fld_e seq,
  input  logic [OP_W-1:0]   opcode,
  output logic [UPC_W-1:0]  nxt,
  output logic              disp_miss
);
  ucs_pkg::disp_t d1, d2;
  logic [UPC_W-1:0] inc;

  assign inc = cur + UPC_W'(1);
  assign d1  = ucs_pkg::lookup_class(opcode);
  assign d2  = ucs_pkg::lookup_mem(opcode);

  always_comb begin
    disp_miss = 1'b0;
    case (seq)
      ucs_pkg::SQ_FETCH: nxt = '0;
      ucs_pkg::SQ_DISP1: begin nxt = d1.tgt; disp_miss = !d1.hit; end
      ucs_pkg::SQ_DISP2: begin nxt = d2.tgt; disp_miss = !d2.hit; end
      default:           nxt = inc;
    endcase
  end
endmodule

// File: rtl/ucs_field_decode.sv
module ucs_field_decode (
  input  ucs_pkg::uinstr_t uinst,
  output ucs_pkg::ctrl_t   ctrl
);
  import ucs_pkg::*;

  always_comb begin
    ctrl = '0;
    ctrl.alu_op    = uinst.alu;
    ctrl.alu_a_sel = (uinst.src1 == S1_A);
    ctrl.alu_b_sel = uinst.src2;
    case (uinst.rg)
      RG_WR_ALU: begin ctrl.reg_wr = 1'b1; ctrl.reg_dst = 1'b1; end
      RG_WR_MDR: begin ctrl.reg_wr = 1'b1; ctrl.wb_from_mem = 1'b1; end
      default: ;
    endcase
    case (uinst.mem)
      MM_RD_PC:  begin ctrl.mem_rd = 1'b1; ctrl.ir_wr = 1'b1; end
      MM_RD_ALU: begin ctrl.mem_rd = 1'b1; ctrl.mem_addr_alu = 1'b1; end
      MM_WR_ALU: begin ctrl.mem_wr = 1'b1; ctrl.mem_addr_alu = 1'b1; end
      default: ;
    endcase
    case (uinst.pcw)
      PW_ALU:  begin ctrl.pc_wr = 1'b1; ctrl.pc_src = 2'b00; end
      PW_COND: begin ctrl.pc_wr_cond = 1'b1; ctrl.pc_src = 2'b01; end
      PW_JUMP: begin ctrl.pc_wr = 1'b1; ctrl.pc_src = 2'b10; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  output logic       pc_wr,
  output logic       pc_wr_cond,
  output logic       mem_addr_alu,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       ir_wr,
  output logic       wb_from_mem,
  output logic [1:0] pc_src,
  output logic [1:0] alu_op,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic       reg_wr,
  output logic       reg_dst,
  output logic [3:0] upc
);
  localparam int UPC_W = ucs_pkg::UPC_W;
  localparam int OP_W  = ucs_pkg::OP_W;

  logic [UPC_W-1:0] upc_q, upc_nxt;
  logic             disp_miss;
  ucs_pkg::uinstr_t uinst;
  ucs_pkg::ctrl_t   ctrl;

  ucs_store #(.UPC_W(UPC_W), .USED(ucs_pkg::USED)) u_store (
    .addr (upc_q),
    .uinst(uinst)
  );

  ucs_next_addr #(.UPC_W(UPC_W), .OP_W(OP_W)) u_next (
    .cur      (upc_q),
    .seq      (uinst.seq),
    .opcode   (opcode),
    .nxt      (upc_nxt),
    .disp_miss(disp_miss)
  );

  ucs_field_decode u_dec (
    .uinst(uinst),
    .ctrl (ctrl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc_q <= '0;
    else        upc_q <= upc_nxt;
  end

  assign upc          = upc_q;
  assign pc_wr        = ctrl.pc_wr;
  assign pc_wr_cond   = ctrl.pc_wr_cond;
  assign mem_addr_alu = ctrl.mem_addr_alu;
  assign mem_rd       = ctrl.mem_rd;
  assign mem_wr       = ctrl.mem_wr;
  assign ir_wr        = ctrl.ir_wr;
  assign wb_from_mem  = ctrl.wb_from_mem;
  assign pc_src       = ctrl.pc_src;
  assign alu_op       = ctrl.alu_op;
  assign alu_a_sel    = ctrl.alu_a_sel;
  assign alu_b_sel    = ctrl.alu_b_sel;
  assign reg_wr       = ctrl.reg_wr;
  assign reg_dst      = ctrl.reg_dst;

  // R2
  fetch_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_q == 4'd0) |=> (upc_q == 4'd1));

  // R2
  step_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_q inside {4'd4, 4'd5, 4'd7, 4'd8, 4'd9}) |=> (upc_q == 4'd0));

  // R3
  class_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_q == 4'd1) |=> (upc_q inside {4'd0, 4'd2, 4'd6, 4'd8, 4'd9}));

  // R4
  memsplit_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_q == 4'd2) |=> (upc_q inside {4'd0, 4'd3, 4'd5}));

  // R5
  miss_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((upc_q inside {4'd1, 4'd2}) && disp_miss) |=> (upc_q == 4'd0));

  // R11
  upc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upc_q <= 4'd9);

  // R8
  ir_at_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |-> (upc_q == 4'd0 && !mem_addr_alu));

  // R9
  pc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_wr, pc_wr_cond}));
endmodule

// File: tb/ucode_sequencer_bench.sv
`timescale 1ns/1ps
module ucode_sequencer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = '0;
  logic pc_wr, pc_wr_cond, mem_addr_alu, mem_rd, mem_wr, ir_wr, wb_from_mem;
  logic [1:0] pc_src, alu_op, alu_b_sel;
  logic alu_a_sel, reg_wr, reg_dst;
  logic [3:0] upc;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ucode_sequencer u_ucode_sequencer (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .mem_addr_alu(mem_addr_alu),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_from_mem(wb_from_mem),
    .pc_src(pc_src), .alu_op(alu_op), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .reg_wr(reg_wr), .reg_dst(reg_dst), .upc(upc)
  );

  function automatic int tbl1(input int op);
    if (op == 0) return 6;
    if (op == 2) return 9;
    if (op == 4) return 8;
    if (op == 35 || op == 43) return 2;
    return 0;
  endfunction

  function automatic int tbl2(input int op);
    if (op == 35) return 3;
    if (op == 43) return 5;
    return 0;
  endfunction

  function automatic int step(input int u, input int op);
    if (u == 1) return tbl1(op);
    if (u == 2) return tbl2(op);
    if (u == 0 || u == 3 || u == 6) return u + 1;
    return 0;
  endfunction

  // {alu_op, alu_a_sel, alu_b_sel}
  function automatic logic [7:0] e_alu(input int u);
    if (u == 0) return 8'b000_00_0_01;
    if (u == 1) return 8'b000_00_0_11;
    if (u == 2) return 8'b000_00_1_10;
    if (u == 6) return 8'b000_10_1_00;
    if (u == 8) return 8'b000_01_1_00;
    return 8'h00;
  endfunction
  // {reg_wr, reg_dst, wb_from_mem}
  function automatic logic [7:0] e_reg(input int u);
    if (u == 4) return 8'b101;
    if (u == 7) return 8'b110;
    return 8'h00;
  endfunction
  // {mem_rd, mem_wr, ir_wr, mem_addr_alu}
  function automatic logic [7:0] e_mem(input int u);
    if (u == 0) return 8'b1010;
    if (u == 3) return 8'b1001;
    if (u == 5) return 8'b0101;
    return 8'h00;
  endfunction
  // {pc_wr, pc_wr_cond, pc_src}
  function automatic logic [7:0] e_pc(input int u);
    if (u == 0) return 8'b1000;
    if (u == 8) return 8'b0101;
    if (u == 9) return 8'b1010;
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h (upc %0d, opcode %0d)", tag, got, exp, upc, opcode);
    end
  endtask

  task automatic check_all(input string seq_tag, input int u);
    check(seq_tag, {4'h0, upc}, 8'(u));
    check("R6 alu fields", {3'b000, alu_op, alu_a_sel, alu_b_sel}, e_alu(u));
    check("R7 register fields", {5'b0, reg_wr, reg_dst, wb_from_mem}, e_reg(u));
    check("R8 memory fields", {4'b0, mem_rd, mem_wr, ir_wr, mem_addr_alu}, e_mem(u));
    check("R9 pc fields", {4'b0, pc_wr, pc_wr_cond, pc_src}, e_pc(u));
    check("R11 upc range", {7'b0, (upc > 4'd9)}, 8'h00);
  endtask

  function automatic string seq_tag(input int prev, input int nxt, input int op);
    if (prev == 1) return (tbl1(op) == 0 && nxt == 0) ? "R5 class miss" : "R3 class table";
    if (prev == 2) return (tbl2(op) == 0 && nxt == 0) ? "R5 split miss" : "R4 split table";
    return "R2 sequencing";
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int mdl;
    // Sweep every opcode with a held value from reset (R1..R9).
    for (int op = 0; op < 64; op++) begin
      @(negedge clk);
      rst_n = 1'b0;
      opcode = 6'(op);
      #1;
      check_all("R1 reset address", 0);
      @(negedge clk);
      rst_n = 1'b1;
      mdl = 0;
      check_all("R1 after release", 0);
      for (int c = 0; c < 6; c++) begin
        int prev;
        prev = mdl;
        @(negedge clk);
        mdl = step(prev, op);
        check_all(seq_tag(prev, mdl, op), mdl);
      end
    end

    // R10: opcode changes every clock, no reset in between.
    for (int k = 0; k < 400; k++) begin
      int prev;
      int pick;
      int ops [8] = '{0, 2, 4, 35, 43, 1, 63, 17};
      pick = ops[(k * 5 + k / 3) % 8];
      opcode = 6'(pick);
      prev = mdl;
      @(negedge clk);
      mdl = step(prev, pick);
      if (prev == 1 || prev == 2) check_all(seq_tag(prev, mdl, pick), mdl);
      else check_all("R10 opcode ignored", mdl);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule